// File: doc/BRIEF.md
# Serial Memory Slave Front-End

This block is the serial front-end of a memory slave with a select-clock-data serial interface. It brings chip select, serial clock, serial data in and an active-low pause input into one system-clock domain through two-flop synchronizers. It then decides when the device counts as selected, pauses and resumes shifting on request, and shifts in an 8-bit instruction that it hands to a downstream decoder. When the instruction is a status read, it shifts the status register back out on a tri-stateable output. The output is modelled as a data bit plus an output enable.

The block also holds the status state: a write-enable latch, a write-busy flag and three persistent protection bits. A power-on reset input puts the interface and the volatile bits into a known state and leaves the persistent bits as they were. The power-on reset input is synchronous to the system clock. A plain system reset (`rst_n`) sets every register, including the persistent bits, to zero.

Top module: `smf_top`

## Requirements
- R1: After a system reset or a power-on reset, the device becomes selected only on a falling edge of chip select that follows a period in which chip select was seen high. A chip select that is already low at that point is ignored: no instruction is taken and `active_o` stays 0 until chip select goes high and then low.
- R2: Power-on reset clears the write-enable latch and the write-busy flag, deselects the device and ends any pause.
- R3: Power-on reset leaves the write-disable bit and both protection bits unchanged, and `stat_we_i` is ignored while power-on reset is high.
- R4: While `por_i` is high, no instruction is accepted, `instr_valid_o` stays 0 and the output is not driven.
- R5: A pause starts only while the device is selected and `hold_n_i` is low with the serial clock low. If the clock is high, entry waits for the clock to go low. While paused, `sdo_oe_o` is 0.
- R6: A pause ends when `hold_n_i` is high with the serial clock low. If the clock is high, the exit waits for the clock to go low.
- R7: While paused, clock edges and serial input are ignored, and the received bit count and shift contents are kept.
- R8: Raising chip select, paused or not, clears the bit count and shift state and ends the pause. A partly received instruction is discarded, so the next selection receives a fresh byte.
- R9: `active_o` is 1 exactly while the device is selected. `standby_o` is 1 while the device is not selected and the write-busy flag is 0.
- R10: Serial input is sampled on rising clock edges, most significant bit first. After 8 bits, `instr_o` takes the byte and `instr_valid_o` pulses for one system cycle. Only the first byte of each selection is taken as an instruction.
- R11: After the status-read code 0x05, the status byte is shifted out most significant bit first. Each bit changes on a falling clock edge, starting with the falling edge that ends the instruction, and the byte repeats every 8 clocks. `sdo_oe_o` is 1 only while selected, not paused, and sending.
- R12: The status byte has the write-busy flag at bit 0, the write-enable latch at bit 1, the protection bits at bits 2 and 3, the write-disable bit at bit 7, and zeros at bits 4 to 6. A `stat_we_i` pulse loads `stat_set_i` = {write-disable, prot1, prot0, write-enable, write-busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, clears all state |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low pause request |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high impedance |
| stat_we_i | input | 1 | Load strobe for the status bits |
| stat_set_i | input | 5 | {write-disable, prot1, prot0, write-enable, write-busy} |
| instr_o | output | 8 | Last received instruction byte |
| instr_valid_o | output | 1 | One-cycle strobe when instr_o is updated |
| active_o | output | 1 | Device selected |
| standby_o | output | 1 | Deselected with no write cycle in progress |

## Verification
Instruction bytes are sent under four patterns: a clean selection, chip select held low through reset, a byte interrupted by a pause, and a byte cut off by deselection. Each pattern gives a different byte, or no strobe at all, when the selection gate, the pause gate or the clearing on deselect is wrong. Status reads are made before and after a power-on reset with every status bit set, which separates the volatile bits from the persistent ones. A read paused with the clock high checks that entry and exit both wait for a low clock and that no output bit is lost.

// File: rtl/smf_pkg.sv
package smf_pkg;
  localparam int unsigned INSTR_W = 8;
  localparam logic [INSTR_W-1:0] OP_READ_STATUS = 8'h05;

  typedef struct packed {
    logic       srwd;
    logic [1:0] bp;
    logic       wel;
    logic       wip;
  } smf_status_t;

  // Map status bits to the outgoing status byte layout.
  function automatic logic [INSTR_W-1:0] pack_status(smf_status_t st);
    logic [INSTR_W-1:0] b;
    b = '0;
    b[0] = st.wip;
    b[1] = st.wel;
    b[2] = st.bp[0];
    b[3] = st.bp[1];
    b[INSTR_W-1] = st.srwd;
    return b;
  endfunction

  // Wrapping counter step.
  function automatic int unsigned step_wrap(int unsigned v, int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/smf_sync.sv
module smf_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/smf_link_ctrl.sv
module smf_link_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic sel_o,
  output logic hold_o
);
  logic cs_q, armed;
  logic cs_fall, hold_enter, hold_leave, clk_low_sel;

  assign cs_fall     = cs_q & ~cs_n_s;
  assign clk_low_sel = sel_o & ~cs_n_s & ~sck_s;
  assign hold_enter  = clk_low_sel & ~hold_o & ~hold_n_s;
  assign hold_leave  = clk_low_sel & hold_o & hold_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      armed  <= 1'b0;
      sel_o  <= 1'b0;
      hold_o <= 1'b0;
    end else if (por_i) begin
      cs_q   <= cs_n_s;
      armed  <= cs_n_s;
      sel_o  <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      cs_q <= cs_n_s;
      if (cs_n_s) armed <= 1'b1;
      if (cs_n_s) begin
        sel_o  <= 1'b0;
        hold_o <= 1'b0;
      end else begin
        if (cs_fall && armed) sel_o <= 1'b1;
        if (hold_enter)      hold_o <= 1'b1;
        else if (hold_leave) hold_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smf_shifter.sv
module smf_shifter
  import smf_pkg::*;
#(
  parameter int unsigned IW = INSTR_W,
  parameter logic [IW-1:0] READ_OP = OP_READ_STATUS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  run_i,
  input  logic                  sck_s,
  input  logic                  sdi_s,
  input  logic [IW-1:0]         status_i,
  output logic [IW-1:0]         instr_o,
  output logic                  instr_vld_o,
  output logic                  sdo_o,
  output logic                  tx_act_o,
  output logic [$clog2(IW)-1:0] rx_cnt_o
);
  localparam int unsigned CW = $clog2(IW);

  logic          sck_q, got;
  logic [IW-1:0] rx_sh, tx_sh, rx_next;
  logic [CW-1:0] tx_cnt;
  logic          rise, fall, last_bit;

  assign rise     = run_i & sck_s & ~sck_q;
  assign fall     = run_i & ~sck_s & sck_q;
  assign rx_next  = {rx_sh[IW-2:0], sdi_s};
  assign last_bit = (rx_cnt_o == CW'(IW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q       <= 1'b0;
      got         <= 1'b0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      tx_cnt      <= '0;
      rx_cnt_o    <= '0;
      instr_o     <= '0;
      instr_vld_o <= 1'b0;
      sdo_o       <= 1'b0;
      tx_act_o    <= 1'b0;
    end else begin
      sck_q       <= sck_s;
      instr_vld_o <= 1'b0;
      if (clr_i) begin
        got      <= 1'b0;
        rx_sh    <= '0;
        tx_sh    <= '0;
        tx_cnt   <= '0;
        rx_cnt_o <= '0;
        sdo_o    <= 1'b0;
        tx_act_o <= 1'b0;
      end else begin
        if (rise && !got) begin
          rx_sh <= rx_next;
          if (last_bit) begin
            rx_cnt_o    <= '0;
            got         <= 1'b1;
            instr_o     <= rx_next;
            instr_vld_o <= 1'b1;
            tx_act_o    <= (rx_next == READ_OP);
            tx_cnt      <= '0;
          end else begin
            rx_cnt_o <= CW'(step_wrap(int'(rx_cnt_o), IW));
          end
        end
        if (fall && tx_act_o) begin
          if (tx_cnt == '0) begin
            sdo_o <= status_i[IW-1];
            tx_sh <= {status_i[IW-2:0], 1'b0};
          end else begin
            sdo_o <= tx_sh[IW-1];
            tx_sh <= {tx_sh[IW-2:0], 1'b0};
          end
          tx_cnt <= CW'(step_wrap(int'(tx_cnt), IW));
        end
      end
    end
  end
endmodule

// File: rtl/smf_top.sv
module smf_top
  import smf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_i,
  input  logic               cs_n_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               hold_n_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  input  logic               stat_we_i,
  input  logic [4:0]         stat_set_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               instr_valid_o,
  output logic               active_o,
  output logic               standby_o
);
  localparam int unsigned NPIN = 4;
  localparam int unsigned CW   = $clog2(INSTR_W);

  logic [NPIN-1:0] pins_raw, pins_s;
  logic cs_n_s, sck_s, sdi_s, hold_n_s;
  logic link_sel, link_hold, tx_act;
  logic [CW-1:0] rx_cnt;
  smf_status_t st;
  logic stat_wel, stat_wip;
  logic [2:0] prot_bits;

  assign pins_raw = {hold_n_i, sdi_i, sck_i, cs_n_i};
  assign {hold_n_s, sdi_s, sck_s, cs_n_s} = pins_s;

  smf_sync #(.W(NPIN), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s)
  );

  smf_link_ctrl u_link (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .cs_n_s(cs_n_s),
    .sck_s(sck_s), .hold_n_s(hold_n_s), .sel_o(link_sel), .hold_o(link_hold)
  );

  smf_shifter #(.IW(INSTR_W), .READ_OP(OP_READ_STATUS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(por_i | ~link_sel),
    .run_i(link_sel & ~link_hold), .sck_s(sck_s), .sdi_s(sdi_s),
    .status_i(pack_status(st)), .instr_o(instr_o),
    .instr_vld_o(instr_valid_o), .sdo_o(sdo_o), .tx_act_o(tx_act),
    .rx_cnt_o(rx_cnt)
  );

  // Volatile status bits: cleared by power-on reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_wel <= 1'b0;
      stat_wip <= 1'b0;
    end else if (por_i) begin
      stat_wel <= 1'b0;
      stat_wip <= 1'b0;
    end else if (stat_we_i) begin
      stat_wel <= stat_set_i[1];
      stat_wip <= stat_set_i[0];
    end
  end

  // Persistent bits: untouched by power-on reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   prot_bits <= '0;
    else if (stat_we_i && !por_i) prot_bits <= stat_set_i[4:2];
  end

  assign st.srwd = prot_bits[2];
  assign st.bp   = prot_bits[1:0];
  assign st.wel  = stat_wel;
  assign st.wip  = stat_wip;

  assign sdo_oe_o  = link_sel & ~link_hold & tx_act;
  assign active_o  = link_sel;
  assign standby_o = ~link_sel & ~stat_wip;
endmodule

// File: rtl/smf_checker.sv
module smf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       por_i,
  input logic       sck_s,
  input logic       link_sel,
  input logic       link_hold,
  input logic [2:0] rx_cnt,
  input logic       stat_wel,
  input logic       stat_wip,
  input logic [2:0] prot_bits,
  input logic       sdo_oe_o,
  input logic       instr_valid_o,
  input logic       active_o,
  input logic       standby_o
);
  assert_por_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (!stat_wel && !stat_wip && !link_sel && !link_hold));

  assert_por_keeps_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> $stable(prot_bits));

  assert_por_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (por_i && $past(por_i)) |-> (!instr_valid_o && !sdo_oe_o));

  assert_hold_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_hold |-> link_sel);

  assert_hold_enter_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_hold) |-> $past(!sck_s));

  assert_hold_exit_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_sel && $fell(link_hold)) |-> $past(!sck_s));

  assert_desel_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_sel |=> (rx_cnt == 3'd0));

  assert_standby_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !active_o);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_o |=> !instr_valid_o);

  assert_oe_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o |-> (link_sel && !link_hold));
endmodule

bind smf_top smf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .por_i(por_i), .sck_s(sck_s),
  .link_sel(link_sel), .link_hold(link_hold), .rx_cnt(rx_cnt),
  .stat_wel(stat_wel), .stat_wip(stat_wip), .prot_bits(prot_bits),
  .sdo_oe_o(sdo_oe_o), .instr_valid_o(instr_valid_o),
  .active_o(active_o), .standby_o(standby_o)
);

// File: tb/smf_top_tb.sv
`timescale 1ns/1ps
module smf_top_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por = 1'b1;
  logic cs_n = 1'b0, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic stat_we = 1'b0;
  logic [4:0] stat_set = '0;
  logic sdo, sdo_oe, ivld, act, stby;
  logic [7:0] instr;

  int n_chk = 0, n_fail = 0, vcnt = 0;
  logic [7:0] vlast = '0;

  always #2.5 clk = ~clk;

  smf_top u_dut (
    .clk(clk), .rst_n(rst_n), .por_i(por), .cs_n_i(cs_n), .sck_i(sck),
    .sdi_i(sdi), .hold_n_i(hold_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .stat_we_i(stat_we), .stat_set_i(stat_set), .instr_o(instr),
    .instr_valid_o(ivld), .active_o(act), .standby_o(stby)
  );

  always @(negedge clk) if (ivld) begin vcnt++; vlast = instr; end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act_v, exp_v);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic spi_bit(input logic b);
    sdi = b; w(HALF); sck = 1'b1; w(HALF); sck = 1'b0; w(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) spi_bit(v[i]);
  endtask

  task automatic sel_on;  cs_n = 1'b1; w(HALF); cs_n = 1'b0; w(HALF); endtask
  task automatic sel_off; cs_n = 1'b1; w(HALF); endtask

  task automatic load_stat(input logic [4:0] v);
    stat_set = v; stat_we = 1'b1; w(1); stat_we = 1'b0; w(2);
  endtask

  task automatic read_status(output logic [7:0] r, output bit oe_ok);
    oe_ok = 1'b1;
    send_byte(8'h05);
    for (int i = 7; i >= 0; i--) begin
      r[i] = sdo;
      if (!sdo_oe) oe_ok = 1'b0;
      if (i > 0) spi_bit(1'b0);
    end
  endtask

  task automatic t_reset;
    chk(act == 1'b0, "R9 active after reset", act, 0);
    chk(stby == 1'b1, "R9 standby after reset", stby, 1);
    chk(sdo_oe == 1'b0, "R11 oe after reset", sdo_oe, 0);
  endtask

  task automatic t_low_at_por;
    int v0;
    v0 = vcnt;
    send_byte(8'hA5);
    chk(vcnt == v0, "R1 low-at-reset byte ignored", vcnt - v0, 0);
    chk(act == 1'b0, "R1 not active", act, 0);
    sel_on();
    chk(act == 1'b1, "R9 active when selected", act, 1);
    send_byte(8'h9A);
    chk(vcnt == v0 + 1 && vlast == 8'h9A, "R10 first instruction", vlast, 8'h9A);
    send_byte(8'h33);
    chk(vcnt == v0 + 1, "R10 second byte not an instruction", vcnt - v0, 1);
    sel_off();
  endtask

  task automatic t_read_status;
    logic [7:0] r; bit ok;
    load_stat(5'b10110);
    sel_on(); read_status(r, ok);
    chk(r == 8'h86, "R12 status layout", r, 8'h86);
    chk(ok, "R11 oe during read", ok, 1);
    spi_bit(1'b0);
    chk(sdo == 1'b1, "R11 status repeats", sdo, 1);
    sel_off();
    chk(sdo_oe == 1'b0, "R11 oe off when deselected", sdo_oe, 0);
  endtask

  task automatic t_por;
    logic [7:0] r; bit ok;
    load_stat(5'b11111);
    chk(stby == 1'b0, "R9 no standby while busy", stby, 0);
    por = 1'b1; w(4);
    stat_set = 5'b00000; stat_we = 1'b1; w(1); stat_we = 1'b0; w(2);
    por = 1'b0; w(4);
    chk(stby == 1'b1, "R2 busy cleared by power-on reset", stby, 1);
    sel_on(); read_status(r, ok);
    chk(r == 8'h8C, "R2 R3 status after power-on reset", r, 8'h8C);
    sel_off();
  endtask

  task automatic t_por_ignore;
    int v0;
    v0 = vcnt;
    por = 1'b1; w(4);
    sel_on(); send_byte(8'h05);
    chk(vcnt == v0, "R4 no instruction during power-on reset", vcnt - v0, 0);
    chk(sdo_oe == 1'b0 && act == 1'b0, "R4 not driven", sdo_oe, 0);
    sel_off(); por = 1'b0; w(4);
  endtask

  task automatic t_hold_bits;
    int v0;
    v0 = vcnt;
    sel_on();
    spi_bit(1); spi_bit(1); spi_bit(0); spi_bit(0);
    hold_n = 1'b0; w(HALF);
    for (int i = 0; i < 4; i++) spi_bit(1'b1);
    hold_n = 1'b1; w(HALF);
    spi_bit(0); spi_bit(0); spi_bit(1); spi_bit(1);
    chk(vcnt == v0 + 1 && vlast == 8'hC3, "R7 bits kept across pause", vlast, 8'hC3);
    sel_off();
  endtask

  task automatic t_hold_defer;
    logic [6:0] rest;
    sel_on(); send_byte(8'h05);
    chk(sdo_oe == 1'b1 && sdo == 1'b1, "R11 first status bit", {sdo_oe, sdo}, 3);
    sck = 1'b1; w(HALF);
    hold_n = 1'b0; w(HALF);
    chk(sdo_oe == 1'b1, "R5 entry waits for low clock", sdo_oe, 1);
    sck = 1'b0; w(HALF);
    chk(sdo_oe == 1'b0, "R5 paused output released", sdo_oe, 0);
    sck = 1'b1; w(HALF);
    hold_n = 1'b1; w(HALF);
    chk(sdo_oe == 1'b0, "R6 exit waits for low clock", sdo_oe, 0);
    sck = 1'b0; w(HALF);
    chk(sdo_oe == 1'b1, "R6 resumed", sdo_oe, 1);
    rest[6] = sdo;
    for (int i = 5; i >= 0; i--) begin spi_bit(1'b0); rest[i] = sdo; end
    chk(rest == 7'h0C, "R7 no output bit lost in pause", rest, 7'h0C);
    sel_off();
  endtask

  task automatic t_desel_in_hold;
    int v0;
    v0 = vcnt;
    sel_on();
    for (int i = 0; i < 4; i++) spi_bit(1'b1);
    hold_n = 1'b0; w(HALF);
    cs_n = 1'b1; w(HALF);
    hold_n = 1'b1; w(HALF);
    cs_n = 1'b0; w(HALF);
    send_byte(8'h3C);
    chk(vcnt == v0 + 1 && vlast == 8'h3C, "R8 deselect in pause clears", vlast, 8'h3C);
    sel_off();
    sel_on();
    for (int i = 0; i < 3; i++) spi_bit(1'b1);
    sel_off(); sel_on();
    send_byte(8'h5A);
    chk(vcnt == v0 + 2 && vlast == 8'h5A, "R8 partial byte discarded", vlast, 8'h5A);
    sel_off();
  endtask

  initial begin
    w(5); rst_n = 1'b1; w(5); por = 1'b0; w(HALF);
    t_reset();
    t_low_at_por();
    t_read_status();
    t_por();
    t_por_ignore();
    t_hold_bits();
    t_hold_defer();
    t_desel_in_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule